// File: doc/BRIEF.md
# Reloadable Down-Counter Timer Bank

This block is a register-mapped timer unit. It holds three down-counting channels and one 40-bit up-counter. The first two channels are 16 bits wide and the third is 32 bits wide. Each channel counts on one of two tick-enable strobes, chosen by a control bit. When a channel passes zero, it either reloads from its reload register or wraps to all ones. In both cases it sets a sticky interrupt flag, and software drops that flag by writing any value to the channel's clear register.

The 40-bit counter has no interrupt. It steps on its own tick strobe and is enabled by a bit in its upper register. Software reads it as two words. The host side is a plain 32-bit port with an 8-bit byte address, a write strobe and a combinational read-data return. Clock generation and the interrupt controller sit outside the block.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset every counter, reload value, control field and interrupt flag is zero, so every register reads as zero and `irq` is 3'b000.
- R2: With bit 6 of control set (periodic), a channel whose counter is zero reloads from its reload register on its next tick and sets its flag. A reload value of N therefore gives one flag every N+1 ticks.
- R3: Control bit 7 enables the channel, bit 6 selects periodic mode and bit 3 selects the fast tick. Control reads back only these three bits; all other bits read as zero.
- R4: A write of any data to a channel's clear register (base+0xC) clears that channel's flag. If an underflow happens in the same cycle, the flag stays set.
- R5: Channel bases are 0x00, 0x20 and 0x80, with reload at +0x0, count at +0x4, control at +0x8 and clear at +0xC. The 40-bit counter sits at 0x60 (low) and 0x64 (high). Any other address reads zero and ignores writes.
- R6: With bit 6 clear (free-running), a channel whose counter is zero wraps to all ones on its next tick and still sets its flag.
- R7: A write to the reload register also loads the counter in the same cycle. Writes to the count register are ignored. A disabled channel holds its count.
- R8: With bit 3 set, a channel counts only on `fast_tick`; with bit 3 clear, it counts only on `slow_tick`.
- R9: Channels 1 and 2 keep only the low 16 bits of a written reload value, and reads return them zero-extended. Channel 3 keeps all 32 bits.
- R10: Bit 8 written at 0x64 enables the 40-bit counter, which then steps by one per `wide_tick`. Reading 0x60 gives bits 31:0. Reading 0x64 gives bits 39:32 in 7:0 and the enable in bit 8. While the counter is disabled it is cleared to zero, and it never raises an interrupt.
- R11: `irq[i]` is the flag of channel i+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_tick | input | 1 | Fast count strobe for the channels |
| slow_tick | input | 1 | Slow count strobe for the channels |
| wide_tick | input | 1 | Count strobe for the 40-bit counter |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 3 | Per-channel interrupt flags |

## Verification
The hardest case to reach from the ports is a clear-register write that lands in the same cycle as an underflow. The bench sets up a periodic channel with a reload of zero, so every tick it receives underflows. It then issues the clear write and a fast tick in the same cycle, and the flag must stay set. Wrap to all ones is reached the same way, by loading a small value and running the channel in free-running mode. The bench also feeds the tick a channel did not select and confirms its count does not move.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

    localparam int NUM_CH        = 3;
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_CLK_BIT  = 3;

    typedef enum logic [1:0] {
        SUB_RELOAD = 2'd0,
        SUB_COUNT  = 2'd1,
        SUB_CTRL   = 2'd2,
        SUB_CLEAR  = 2'd3
    } sub_t;

    typedef struct packed {
        logic en;
        logic periodic;
        logic fast_sel;
    } ctrl_t;

    function automatic logic [3:0] chan_page(input int idx);
        case (idx)
            0:       chan_page = 4'h0;
            1:       chan_page = 4'h2;
            default: chan_page = 4'h8;
        endcase
    endfunction

endpackage

// File: rtl/ttb_channel.sv
module ttb_channel
    import ttb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  sub_t              sub,
    input  logic              wr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              fast_tick,
    input  logic              slow_tick,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        ctrl_t            ctrl;
        logic             flag;
    } state_t;

    state_t st_q, st_d;
    logic   ld_wr, ctl_wr, clr_wr, tick, underflow;

    always_comb begin
        st_d      = st_q;
        ld_wr     = sel && wr && (sub == SUB_RELOAD);
        ctl_wr    = sel && wr && (sub == SUB_CTRL);
        clr_wr    = sel && wr && (sub == SUB_CLEAR);
        tick      = st_q.ctrl.en && (st_q.ctrl.fast_sel ? fast_tick : slow_tick);
        underflow = tick && (st_q.count == '0);
        if (ld_wr) begin
            st_d.reload = wdata;
            st_d.count  = wdata;
        end else if (tick) begin
            if (underflow)
                st_d.count = st_q.ctrl.periodic ? st_q.reload : '1;
            else
                st_d.count = st_q.count - 1'b1;
        end
        if (ctl_wr) begin
            st_d.ctrl.en       = wdata[CTRL_EN_BIT];
            st_d.ctrl.periodic = wdata[CTRL_MODE_BIT];
            st_d.ctrl.fast_sel = wdata[CTRL_CLK_BIT];
        end
        if (clr_wr)
            st_d.flag = 1'b0;
        if (underflow)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (sub)
            SUB_RELOAD: rdata[CNT_W-1:0] = st_q.reload;
            SUB_COUNT:  rdata[CNT_W-1:0] = st_q.count;
            SUB_CTRL: begin
                rdata[CTRL_EN_BIT]   = st_q.ctrl.en;
                rdata[CTRL_MODE_BIT] = st_q.ctrl.periodic;
                rdata[CTRL_CLK_BIT]  = st_q.ctrl.fast_sel;
            end
            default:    rdata = '0;
        endcase
    end

    assign irq = st_q.flag;

    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && st_q.ctrl.periodic && !ld_wr) |=> (st_q.count == $past(st_q.reload))); // R2
    AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> st_q.flag); // R4
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !underflow) |=> !st_q.flag); // R4
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !st_q.ctrl.periodic && !ld_wr) |=> (st_q.count == '1)); // R6
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.en && !ld_wr) |=> $stable(st_q.count)); // R7

endmodule

// File: rtl/ttb_freerun.sv
module ttb_freerun #(
    parameter int CNT_W  = 40,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo,
    input  logic              sel_hi,
    input  logic              wr,
    input  logic              en_bit,
    input  logic              tick,
    output logic [DATA_W-1:0] rdata
);

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
    } fr_state_t;

    fr_state_t fr_q, fr_d;

    always_comb begin
        fr_d = fr_q;
        if (sel_hi && wr)
            fr_d.en = en_bit;
        if (!fr_q.en)
            fr_d.cnt = '0;
        else if (tick)
            fr_d.cnt = fr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    always_comb begin
        rdata = '0;
        if (sel_lo) begin
            rdata = fr_q.cnt[DATA_W-1:0];
        end else if (sel_hi) begin
            rdata[HI_W-1:0] = fr_q.cnt[CNT_W-1:DATA_W];
            rdata[HI_W]     = fr_q.en;
        end
    end

    AST_WIDE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !fr_q.en |=> (fr_q.cnt == '0)); // R10
    AST_WIDE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.en && tick) |=> (fr_q.cnt == $past(fr_q.cnt) + 1'b1)); // R10

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import ttb_pkg::*;
#(
    parameter int NARROW_W = 16,
    parameter int WIDE_W   = 32,
    parameter int FREE_W   = 40,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_tick,
    input  logic              slow_tick,
    input  logic              wide_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam logic [ADDR_W-3:0] FREE_LO_WORD = (ADDR_W-2)'(8'h60 >> 2);
    localparam logic [ADDR_W-3:0] FREE_HI_WORD = (ADDR_W-2)'(8'h64 >> 2);

    logic              aligned;
    logic [NUM_CH-1:0] ch_hit;
    logic [DATA_W-1:0] ch_rdata [NUM_CH];
    logic [DATA_W-1:0] fr_rdata;
    logic              fr_lo, fr_hi;
    sub_t              sub;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sub     = sub_t'(bus_addr[3:2]);
    assign fr_lo   = aligned && (bus_addr[ADDR_W-1:2] == FREE_LO_WORD);
    assign fr_hi   = aligned && (bus_addr[ADDR_W-1:2] == FREE_HI_WORD);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int W = (i == NUM_CH - 1) ? WIDE_W : NARROW_W;
        assign ch_hit[i] = aligned && (bus_addr[ADDR_W-1:4] == chan_page(i));
        ttb_channel #(.CNT_W(W), .DATA_W(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (ch_hit[i]),
            .sub       (sub),
            .wr        (bus_wr),
            .wdata     (bus_wdata[W-1:0]),
            .fast_tick (fast_tick),
            .slow_tick (slow_tick),
            .rdata     (ch_rdata[i]),
            .irq       (irq[i])
        );
    end

    ttb_freerun #(.CNT_W(FREE_W), .DATA_W(DATA_W)) u_free (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_lo (fr_lo),
        .sel_hi (fr_hi),
        .wr     (bus_wr),
        .en_bit (bus_wdata[FREE_W-DATA_W]),
        .tick   (wide_tick),
        .rdata  (fr_rdata)
    );

    always_comb begin
        bus_rdata = fr_rdata;
        for (int i = 0; i < NUM_CH; i++)
            if (ch_hit[i]) bus_rdata = bus_rdata | ch_rdata[i];
    end

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_hit, fr_lo, fr_hi})); // R5

endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0, slow_tick = 1'b0, wide_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        bit          is_irq;
        string       tag;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    tick_timer_bank u0 (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .slow_tick(slow_tick),
        .wide_tick(wide_tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: pops one expected item per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = it.is_irq ? {29'd0, irq} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic wr_reg_tick(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; fast_tick = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; fast_tick = 1'b0;
    endtask

    task automatic pulse(input bit f, input bit s, input bit w, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            fast_tick = f; slow_tick = s; wide_tick = w;
            @(posedge clk); #1;
            fast_tick = 1'b0; slow_tick = 1'b0; wide_tick = 1'b0;
        end
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 1'b0;
        it.addr = a; it.exp = e; it.is_irq = 1'b0; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    task automatic expect_irq(input logic [2:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.addr = 8'h00; it.exp = {29'd0, e}; it.is_irq = 1'b1; it.tag = tag;
        sb.push_back(it);
        @(posedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        expect_rd(8'h08, 32'h0, "R1 ctrl after reset");
        expect_rd(8'h04, 32'h0, "R1 count after reset");
        expect_rd(8'h64, 32'h0, "R1 wide high after reset");
        expect_irq(3'b000, "R1 irq after reset");

        // channel 1 periodic, reload 3
        wr_reg(8'h00, 32'd3);
        expect_rd(8'h04, 32'd3, "R7 reload write loads count");
        wr_reg(8'h08, 32'h0000_00C8);
        pulse(1, 0, 0, 3);
        expect_rd(8'h04, 32'd0, "R2 count at zero");
        expect_irq(3'b000, "R2 no flag before N+1");
        pulse(1, 0, 0, 1);
        expect_rd(8'h04, 32'd3, "R2 reload after underflow");
        expect_irq(3'b001, "R11 flag on irq[0]");
        expect_rd(8'h08, 32'h0000_00C8, "R3 ctrl readback");
        wr_reg(8'h08, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0000_00C8, "R3 only bits 7 6 3 kept");
        wr_reg(8'h0C, 32'h0000_1234);
        expect_irq(3'b000, "R4 clear by any value");
        wr_reg(8'h04, 32'h55);
        expect_rd(8'h04, 32'd3, "R7 count write ignored");

        // tick selection and disable
        pulse(0, 1, 0, 2);
        expect_rd(8'h04, 32'd3, "R8 slow tick ignored on fast select");
        wr_reg(8'h08, 32'h40);
        pulse(1, 0, 0, 2);
        expect_rd(8'h04, 32'd3, "R7 disabled channel holds");
        wr_reg(8'h08, 32'h80);
        pulse(0, 1, 0, 3);
        expect_rd(8'h04, 32'd0, "R8 slow tick counts");
        expect_irq(3'b000, "R6 no flag before wrap");
        pulse(0, 1, 0, 1);
        expect_rd(8'h04, 32'h0000_FFFF, "R6 wrap to all ones");
        expect_irq(3'b001, "R6 flag on wrap");
        pulse(1, 0, 0, 1);
        expect_rd(8'h04, 32'h0000_FFFF, "R8 fast tick ignored on slow select");
        wr_reg(8'h0C, 32'h0);
        wr_reg(8'h08, 32'h0);

        // channel 2: clear collides with underflow
        wr_reg(8'h20, 32'd0);
        wr_reg(8'h28, 32'hC8);
        wr_reg_tick(8'h2C, 32'h0);
        expect_irq(3'b010, "R4 underflow wins over clear");
        wr_reg(8'h28, 32'h0);
        wr_reg(8'h2C, 32'h0);
        expect_irq(3'b000, "R4 clear channel 2");

        // widths
        wr_reg(8'h00, 32'h0001_2345);
        expect_rd(8'h04, 32'h0000_2345, "R9 channel 1 truncates to 16 bits");
        wr_reg(8'h80, 32'h1234_5678);
        expect_rd(8'h84, 32'h1234_5678, "R9 channel 3 keeps 32 bits");
        wr_reg(8'h80, 32'd1);
        wr_reg(8'h88, 32'hC8);
        pulse(1, 0, 0, 2);
        expect_irq(3'b100, "R11 flag on irq[2]");
        expect_rd(8'h84, 32'd1, "R2 channel 3 reload");
        wr_reg(8'h8C, 32'h0);
        wr_reg(8'h88, 32'h88);
        wr_reg(8'h80, 32'd0);
        pulse(1, 0, 0, 1);
        expect_rd(8'h84, 32'hFFFF_FFFF, "R6 channel 3 wrap");
        wr_reg(8'h88, 32'h0);
        wr_reg(8'h8C, 32'h0);

        // 40-bit counter
        wr_reg(8'h64, 32'h100);
        pulse(0, 0, 1, 5);
        expect_rd(8'h60, 32'd5, "R10 wide counts ticks");
        expect_rd(8'h64, 32'h100, "R10 wide high and enable");
        wr_reg(8'h60, 32'hFFFF);
        expect_rd(8'h60, 32'd5, "R10 low word not writable");
        expect_irq(3'b000, "R10 wide never flags");
        wr_reg(8'h64, 32'h0);
        expect_rd(8'h60, 32'd0, "R10 cleared when disabled");

        // map holes
        expect_rd(8'h40, 32'h0, "R5 unmapped reads zero");
        expect_rd(8'h10, 32'h0, "R5 hole after channel 1");
        wr_reg(8'h48, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0, "R5 unmapped write ignored");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule